// File: doc/BRIEF.md
# Peak-Current PWM Cycle Sequencer

This block is the digital timing core of a fixed-frequency, peak-current-mode DC-DC converter. It divides the system clock down to a switching period. The period is either a built-in default or a value selected on an input and clamped to a legal window. The block turns the power switch on at the start of every period. It turns the switch off when the analog peak-current comparator reports a trip after a leading-edge blanking window, or when the period reaches its three-quarter duty limit, whichever comes first.

Two fault flags suppress whole switching periods: a low-load flag and a short-circuit flag. An average-overcurrent flag, or a low enable from the hot-swap power-good signal, stops the converter and holds it reset. When the stop condition clears, the converter starts again. A digital peak-limit code ramps from zero to full scale over a programmable soft-start time, and this code drives the reference of the analog comparator. The ramp starts from zero after every stop.

Top module: `pwm_cycle_seq`

## Requirements
- R1: While `rst_n` or `enable` is sampled low, the next cycle has `sw_on`, `cyc_start` and `peak_lim` all zero.
- R2: With `freq_mode` = 0, `cyc_start` pulses once every `DEF_PER` clocks. The first pulse comes on the cycle after the run condition is first sampled true.
- R3: With `freq_mode` = 1, the period equals `period_sel` clamped to [`MIN_PER`, `MAX_PER`]. A new selection takes effect at the next period boundary.
- R4: With no comparator trip, `sw_on` is high for exactly floor(3·P/4) clocks starting on the `cyc_start` cycle, where P is the current period.
- R5: A peak trip sampled high at a clock edge that ends period count k, with k ≥ `BLANK_CYC` and `sw_on` high, drops `sw_on` from count k+1 until the end of the period.
- R6: A trip sampled at a count below `BLANK_CYC` has no effect on the pulse.
- R7: If `low_cur` or `short_det` is high at the edge that starts a period, `sw_on` stays low for that whole period, while `cyc_start` keeps its timing.
- R8: A high `avg_ovc` sampled at an edge forces `sw_on` low and `peak_lim` to zero on the following cycle, and holds them there while the flag stays high.
- R9: After each start, `peak_lim` equals floor(r / `SS_STEP`), saturating at all-ones, where r is the number of consecutive running edges. The ramp restarts from zero after every stop.
- R10: `sw_on` is low for at least one clock before every `cyc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Power-good from the hot-swap stage; low stops and resets the sequencer |
| freq_mode | input | 1 | 0 selects the default period, 1 selects `period_sel` |
| period_sel | input | PER_W | Requested period in clocks, clamped to [MIN_PER, MAX_PER] |
| ipk_trip | input | 1 | Peak-current comparator flag |
| low_cur | input | 1 | Light-load flag; skips periods |
| short_det | input | 1 | Short-circuit flag; skips periods |
| avg_ovc | input | 1 | Average overcurrent flag; holds the converter in reset |
| sw_on | output | 1 | Power switch gate command |
| cyc_start | output | 1 | One-clock pulse on the first count of each period |
| peak_lim | output | LIM_W | Soft-start peak-limit code for the comparator reference |

## Verification
The assertions assume that the flags are already synchronous to `clk`. They also assume that the default period lies inside the clamp window, and that three quarters of the smallest period is longer than the blanking window. The blanking and duty checks rely on those last two points. The stimulus uses a short default period, a short blanking window and a fast soft-start step. It changes every input on the falling edge, so each flag is seen at a known period count. The comparator flag is placed before the blanking limit, after it, and held high throughout. The skip flags and the overcurrent flag are raised only between period boundaries, and each is cleared again before the next test starts.

// File: rtl/pwm_seq_pkg.sv
// Shared helpers for the PWM cycle sequencer.
// Assumes period values fit in 16 bits.
package pwm_seq_pkg;

    // Duty limit as a fraction CAP_NUM / 2**CAP_SHIFT of the period.
    localparam int CAP_SHIFT = 2;

    // Returns floor(3*p/4), the maximum on-time in clocks for period p.
    function automatic logic [15:0] duty_limit(input logic [15:0] p);
        logic [17:0] t;
        t = ({2'b00, p} << 1) + {2'b00, p};
        return t[17:CAP_SHIFT];
    endfunction

endpackage

// File: rtl/pwm_period_gen.sv
// Switching period counter.
// Counts 0..per_q-1 while running, restarts at 0 on the first running edge,
// and latches the period choice only at period boundaries.
// Assumes MIN_PER <= DEF_PER <= MAX_PER < 2**PER_W.
module pwm_period_gen #(
    parameter int PER_W   = 10,
    parameter int DEF_PER = 400,
    parameter int MIN_PER = 200,
    parameter int MAX_PER = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_d,
    input  logic             freq_mode,
    input  logic [PER_W-1:0] period_sel,
    output logic             run_q,
    output logic [PER_W-1:0] cnt,
    output logic [PER_W-1:0] per_q,
    output logic             wrap_d,
    output logic             cyc_start
);
    localparam logic [PER_W-1:0] DEF_P = PER_W'(DEF_PER);
    localparam logic [PER_W-1:0] MIN_P = PER_W'(MIN_PER);
    localparam logic [PER_W-1:0] MAX_P = PER_W'(MAX_PER);

    logic [PER_W-1:0] sel_per;

    // Period choice: default, or the requested value clamped to the window.
    always_comb begin
        if (!freq_mode)              sel_per = DEF_P;
        else if (period_sel < MIN_P) sel_per = MIN_P;
        else if (period_sel > MAX_P) sel_per = MAX_P;
        else                         sel_per = period_sel;
    end

    assign wrap_d    = run_d & (~run_q | (cnt == per_q - PER_W'(1)));
    assign cyc_start = run_q & (cnt == '0);

    // Period counter and latched period length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt   <= '0;
            per_q <= DEF_P;
        end else begin
            run_q <= run_d;
            if (!run_d || wrap_d) begin
                cnt   <= '0;
                per_q <= sel_per;
            end else begin
                cnt <= cnt + PER_W'(1);
            end
        end
    end

    AST_PERIOD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (per_q >= MIN_P && per_q <= MAX_P)); // R3

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt < per_q)); // R2

endmodule

// File: rtl/pwm_softstart.sv
// Soft-start ramp of the peak-limit code.
// The code rises by one every SS_STEP running clocks and saturates at
// all-ones. It is cleared whenever the run condition is low.
module pwm_softstart #(
    parameter int LIM_W   = 8,
    parameter int SS_STEP = 1569
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_d,
    input  logic             run_q,
    output logic [LIM_W-1:0] peak_lim
);
    localparam int TICK_W = $clog2(SS_STEP + 1);
    localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(SS_STEP - 1);
    localparam logic [LIM_W-1:0]  FULL      = '1;

    logic [TICK_W-1:0] tick;

    // Step timer and ramp code.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_d) begin
            tick     <= '0;
            peak_lim <= '0;
        end else if (peak_lim != FULL) begin
            if (tick == LAST_TICK) begin
                tick     <= '0;
                peak_lim <= peak_lim + LIM_W'(1);
            end else begin
                tick <= tick + TICK_W'(1);
            end
        end
    end

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && $past(run_q)) |->
            (peak_lim == $past(peak_lim) || peak_lim == $past(peak_lim) + LIM_W'(1))); // R9

    AST_RAMP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (peak_lim == '0)); // R8

endmodule

// File: rtl/pwm_pulse_ctrl.sv
// Switch pulse control within one period.
// The pulse opens at count 0 unless a skip flag was present at the
// boundary. It closes on a comparator trip seen after the blanking window,
// or at the duty limit. Assumes duty_limit(MIN_PER) > BLANK_CYC.
module pwm_pulse_ctrl
    import pwm_seq_pkg::*;
#(
    parameter int PER_W     = 10,
    parameter int BLANK_CYC = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_d,
    input  logic             run_q,
    input  logic             wrap_d,
    input  logic [PER_W-1:0] cnt,
    input  logic [PER_W-1:0] per_q,
    input  logic             ipk_trip,
    input  logic             low_cur,
    input  logic             short_det,
    output logic             sw_on
);
    localparam logic [PER_W-1:0] BLANK_C = PER_W'(BLANK_CYC);

    logic             skip_q;
    logic             trip_q;
    logic [PER_W-1:0] cap;

    assign cap   = PER_W'(duty_limit(16'(per_q)));
    assign sw_on = run_q & ~skip_q & ~trip_q & (cnt < cap);

    // Per-period skip decision and latched comparator trip.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_d) begin
            skip_q <= 1'b1;
            trip_q <= 1'b0;
        end else if (wrap_d) begin
            skip_q <= low_cur | short_det;
            trip_q <= 1'b0;
        end else if (sw_on && cnt >= BLANK_C && ipk_trip) begin
            trip_q <= 1'b1;
        end
    end

    AST_BLANK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(sw_on) && $past(cnt) < BLANK_C && run_q && cnt != '0 && cnt < cap)
            |-> sw_on); // R6

    AST_SKIP_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && cnt == '0 && $past(run_q) && $past(low_cur || short_det))
            |-> !sw_on); // R7

endmodule

// File: rtl/pwm_cycle_seq.sv
// Top of the peak-current PWM cycle sequencer.
// Joins the period counter, the pulse control and the soft-start ramp.
// Run condition: enable high and avg_ovc low, as sampled at each edge.
// Assumes all flags are synchronous to clk.
module pwm_cycle_seq
    import pwm_seq_pkg::*;
#(
    parameter int PER_W     = 10,
    parameter int DEF_PER   = 400,
    parameter int MIN_PER   = 200,
    parameter int MAX_PER   = 1000,
    parameter int BLANK_CYC = 20,
    parameter int LIM_W     = 8,
    parameter int SS_STEP   = 1569
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             freq_mode,
    input  logic [PER_W-1:0] period_sel,
    input  logic             ipk_trip,
    input  logic             low_cur,
    input  logic             short_det,
    input  logic             avg_ovc,
    output logic             sw_on,
    output logic             cyc_start,
    output logic [LIM_W-1:0] peak_lim
);
    logic             run_d;
    logic             run_q;
    logic             wrap_d;
    logic [PER_W-1:0] cnt;
    logic [PER_W-1:0] per_q;
    logic [PER_W-1:0] hi_len;

    assign run_d = enable & ~avg_ovc;

    pwm_period_gen #(
        .PER_W(PER_W), .DEF_PER(DEF_PER), .MIN_PER(MIN_PER), .MAX_PER(MAX_PER)
    ) u_period (
        .clk(clk), .rst_n(rst_n), .run_d(run_d), .freq_mode(freq_mode),
        .period_sel(period_sel), .run_q(run_q), .cnt(cnt), .per_q(per_q),
        .wrap_d(wrap_d), .cyc_start(cyc_start)
    );

    pwm_pulse_ctrl #(
        .PER_W(PER_W), .BLANK_CYC(BLANK_CYC)
    ) u_pulse (
        .clk(clk), .rst_n(rst_n), .run_d(run_d), .run_q(run_q), .wrap_d(wrap_d),
        .cnt(cnt), .per_q(per_q), .ipk_trip(ipk_trip), .low_cur(low_cur),
        .short_det(short_det), .sw_on(sw_on)
    );

    pwm_softstart #(
        .LIM_W(LIM_W), .SS_STEP(SS_STEP)
    ) u_ss (
        .clk(clk), .rst_n(rst_n), .run_d(run_d), .run_q(run_q), .peak_lim(peak_lim)
    );

    // Length of the current on-pulse so far, for the duty check.
    always_ff @(posedge clk) begin
        if (!rst_n) hi_len <= '0;
        else        hi_len <= sw_on ? hi_len + PER_W'(1) : '0;
    end

    AST_DUTY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        sw_on |-> (hi_len < PER_W'(duty_limit(16'(per_q))))); // R4

    AST_GAP_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_start && sw_on) |-> !$past(sw_on)); // R10

    AST_OVC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(avg_ovc) |-> (!sw_on && peak_lim == '0)); // R8

    AST_ENABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> (!sw_on && !cyc_start)); // R1

endmodule

// File: tb/sim_pwm_cycle_seq.sv
module sim_pwm_cycle_seq;
    localparam int PW = 10, DP = 40, MINP = 20, MAXP = 100, BL = 4, LW = 4, SS = 6;
    localparam int FULL = (1 << LW) - 1;

    logic clk = 0, rst_n = 0, enable = 0, freq_mode = 0;
    logic [PW-1:0] period_sel = '0;
    logic ipk_trip = 0, low_cur = 0, short_det = 0, avg_ovc = 0;
    logic sw_on, cyc_start;
    logic [LW-1:0] peak_lim;

    int errors = 0, checks = 0, cycles = 0;
    bit done = 0, started = 0;
    string cur_req = "R1";

    // Behavioural reference state.
    bit m_run = 0, m_skip = 1, m_trip = 0;
    int m_cnt = 0, m_per = DP, m_r = 0;

    always #5 clk = ~clk;

    pwm_cycle_seq #(.PER_W(PW), .DEF_PER(DP), .MIN_PER(MINP), .MAX_PER(MAXP),
                    .BLANK_CYC(BL), .LIM_W(LW), .SS_STEP(SS)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .freq_mode(freq_mode),
        .period_sel(period_sel), .ipk_trip(ipk_trip), .low_cur(low_cur),
        .short_det(short_det), .avg_ovc(avg_ovc), .sw_on(sw_on),
        .cyc_start(cyc_start), .peak_lim(peak_lim));

    function automatic bit exp_sw();
        return m_run && !m_skip && !m_trip && (m_cnt < (m_per * 3) / 4);
    endfunction

    function automatic int exp_lim();
        int v = m_r / SS;
        return (v > FULL) ? FULL : v;
    endfunction

    function automatic int sel_period();
        int p = int'(period_sel);
        if (!freq_mode) return DP;
        if (p < MINP) return MINP;
        if (p > MAXP) return MAXP;
        return p;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        bit rd, nt;
        started = 1;
        if (!rst_n) begin
            m_run = 0; m_skip = 1; m_trip = 0; m_cnt = 0; m_per = DP; m_r = 0;
        end else begin
            rd = enable && !avg_ovc;
            nt = exp_sw() && (m_cnt >= BL) && ipk_trip;
            if (!rd) begin
                m_cnt = 0; m_per = sel_period(); m_skip = 1; m_trip = 0; m_r = 0;
            end else if (!m_run || m_cnt == m_per - 1) begin
                m_cnt = 0; m_per = sel_period(); m_skip = low_cur || short_det;
                m_trip = 0; m_r++;
            end else begin
                m_cnt++; m_trip = m_trip || nt; m_r++;
            end
            m_run = rd;
        end
    end

    // Compare outputs with the model on every falling edge.
    always @(negedge clk) begin
        if (started && !done) begin
            chk(cur_req, "sw_on", int'(sw_on), int'(exp_sw()));
            chk(cur_req, "cyc_start", int'(cyc_start), int'(m_run && m_cnt == 0));
            chk(cur_req, "peak_lim", int'(peak_lim), exp_lim());
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Measure one period: trip_at < 0 holds the trip high, else it pulses at that count.
    task automatic run_cycle(input int trip_at, output int len, output int hi, output bit last_sw);
        len = 0; hi = 0; last_sw = 0;
        @(negedge clk);
        while (!cyc_start) @(negedge clk);
        do begin
            if (sw_on) hi++;
            last_sw = sw_on;
            ipk_trip = (trip_at < 0) || (len == trip_at);
            len++;
            @(negedge clk);
        end while (!cyc_start && len < 2000);
        ipk_trip = 0;
    endtask

    initial begin
        int len, hi;
        bit ls;
        repeat (4) @(negedge clk);
        chk("R1", "sw_on in reset", sw_on, 0);
        chk("R1", "peak_lim in reset", peak_lim, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);
        chk("R1", "cyc_start with enable low", cyc_start, 0);

        cur_req = "R2"; enable = 1;
        run_cycle(999, len, hi, ls);
        chk("R2", "default period", len, DP);
        chk("R4", "duty limit", hi, 30);
        chk("R10", "low before next start", ls, 0);
        run_cycle(999, len, hi, ls);
        run_cycle(999, len, hi, ls);
        chk("R9", "ramp at full", peak_lim, FULL);

        cur_req = "R6";
        run_cycle(2, len, hi, ls);
        chk("R6", "trip in blank ignored", hi, 30);
        cur_req = "R5";
        run_cycle(10, len, hi, ls);
        chk("R5", "trip at count 10", hi, 11);
        run_cycle(-1, len, hi, ls);
        chk("R5", "trip held high", hi, BL + 1);

        cur_req = "R3"; freq_mode = 1; period_sel = 60;
        run_cycle(999, len, hi, ls);
        chk("R3", "period 60", len, 60);
        chk("R4", "duty at 60", hi, 45);
        period_sel = 5;
        run_cycle(999, len, hi, ls);
        chk("R3", "clamped low", len, MINP);
        period_sel = 900;
        run_cycle(999, len, hi, ls);
        chk("R3", "clamped high", len, MAXP);
        chk("R4", "duty at 100", hi, 75);
        chk("R10", "low before start at 100", ls, 0);
        freq_mode = 0;

        cur_req = "R7"; low_cur = 1;
        run_cycle(999, len, hi, ls);
        chk("R7", "low_cur skip", hi, 0);
        chk("R7", "period kept", len, DP);
        low_cur = 0; short_det = 1;
        run_cycle(999, len, hi, ls);
        chk("R7", "short skip", hi, 0);
        short_det = 0;
        run_cycle(999, len, hi, ls);
        chk("R7", "resume after skip", hi, 30);

        cur_req = "R8"; avg_ovc = 1;
        @(negedge clk);
        chk("R8", "switch off", sw_on, 0);
        chk("R8", "limit cleared", peak_lim, 0);
        repeat (20) begin
            @(negedge clk);
            chk("R8", "held off", sw_on, 0);
        end
        cur_req = "R9"; avg_ovc = 0;
        @(negedge clk);
        chk("R9", "ramp restarts", peak_lim, 0);
        chk("R9", "start after clear", cyc_start, 1);
        repeat (6) @(negedge clk);
        chk("R9", "first step", peak_lim, 1);
        repeat (90) @(negedge clk);
        chk("R9", "ramp full again", peak_lim, FULL);

        cur_req = "R1"; enable = 0;
        @(negedge clk);
        chk("R1", "enable low off", sw_on, 0);
        chk("R1", "enable low limit", peak_lim, 0);
        enable = 1;
        run_cycle(999, len, hi, ls);
        chk("R2", "period after enable", len, DP);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule